// File: doc/BRIEF.md
# Shift-and-Add Output Accumulator

This block is the final stage of a multi-cell multiply-accumulate filter. It takes the running sums of eight filter cells and produces one 26-bit result. A 3-bit address picks one cell sum on each clock. A mode input then decides what happens. The stage either loads the picked value into its own register, or adds the picked value to its previous contents after an arithmetic right shift of 8 bits.

The shifted feedback lets a wide word be built from several 8-bit slices. For example, a 16-bit sample times an 8-bit coefficient can be formed in two passes. The first pass loads the product of the low byte. The second pass adds the product of the high byte to that value shifted down by one byte. The 8 low bits shifted out after the first pass are read from the sum bus before the second pass overwrites them.

The sum bus is split into a low field and a high field. Each field has its own enable, so a narrow consumer can read either half.

Top module: `shaddOutStage`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the stage register to zero.
- R2: `cellSel` value k (0..7) selects cell k, where cell k occupies bits [26k+25:26k] of `cellAccFlat`.
- R3: With `shiftAdd` low at a clock edge, the register takes the selected cell value unchanged.
- R4: With `shiftAdd` high at a clock edge, the register takes the selected cell value plus its old contents shifted right by 8 bits. The shift copies old bit 25 into the 8 vacated upper bits.
- R5: The addition wraps modulo 2^26, with no saturation and no overflow flag.
- R6: `sumOut[15:0]` shows register bits 15..0 while `enLow` is high and reads zero while it is low.
- R7: `sumOut[25:16]` shows register bits 25..16 while `enHigh` is high and reads zero while it is low.
- R8: The register changes only at the clock edge that samples the address and mode. A new result is visible one clock after those inputs are presented.
- R9: Two passes compose a 16 x 8 signed product. The first pass loads the low-byte product, and its bits 7..0 are read off. The second pass adds the high-byte product to the shifted first-pass value. The second-pass result concatenated with those 8 bits equals the full product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cellAccFlat | input | 208 | Eight 26-bit cell sums, cell k at bits [26k+25:26k] |
| cellSel | input | 3 | Cell address |
| shiftAdd | input | 1 | 1: add to shifted old sum; 0: load |
| enLow | input | 1 | Enable for sum bits 15..0 |
| enHigh | input | 1 | Enable for sum bits 25..16 |
| sumOut | output | 26 | Result, each field zero while its enable is low |

## Verification
The bench first loads a distinct value through each address, which exposes any mis-wired select. It then runs forced negative feedback to tell an arithmetic shift from a logical one, and a sum that wraps through zero to show there is no saturation. Signed 16 x 8 products are split into two passes and compared against a direct multiplication, including the most negative operands. The remaining cycles mix random cell values, addresses, modes and enable pairs, so that load, shifted add and field gating are each seen starting from many previous sums.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clr;       // clear accumulator
    logic load;      // load selected cell
    logic add;       // add selected cell to shifted old sum
    logic showLow;   // drive low field
    logic showHigh;  // drive high field
  } shaddStrobeT;
endpackage

// File: rtl/shaddCtrl.sv
module shaddCtrl
  import shadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        shiftAdd,
  input  logic        enLow,
  input  logic        enHigh,
  output shaddStrobeT strobes
);
  always_comb begin
    strobes.clr      = rst;
    strobes.load     = !rst && !shiftAdd;
    strobes.add      = !rst && shiftAdd;
    strobes.showLow  = enLow;
    strobes.showHigh = enHigh;
  end

  // exactly one update operation outside reset
  AST_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    $countones({strobes.load, strobes.add}) == 1); // R3
endmodule

// File: rtl/shaddDatapath.sv
module shaddDatapath
  import shadd_pkg::*;
#(
  parameter int CELLS = 8,
  parameter int ACC_W = 26,
  parameter int SHIFT = 8,
  parameter int LOW_W = 16,
  localparam int SEL_W = $clog2(CELLS)
)(
  input  logic                   clk,
  input  logic                   rst,
  input  shaddStrobeT            strobes,
  input  logic [CELLS*ACC_W-1:0] cellAccFlat,
  input  logic [SEL_W-1:0]       cellSel,
  output logic [ACC_W-1:0]       sumOut
);
  logic [ACC_W-1:0] cellArr [CELLS];
  logic [ACC_W-1:0] selVal;
  logic [ACC_W-1:0] shiftedAcc;
  logic [ACC_W-1:0] accQ;

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    assign cellArr[g] = cellAccFlat[g*ACC_W +: ACC_W];
  end

  assign selVal     = cellArr[cellSel];
  assign shiftedAcc = $signed(accQ) >>> SHIFT;

  always_ff @(posedge clk) begin
    if (strobes.clr)       accQ <= '0;
    else if (strobes.add)  accQ <= selVal + shiftedAcc;
    else if (strobes.load) accQ <= selVal;
  end

  // field gating
  assign sumOut[LOW_W-1:0]     = strobes.showLow  ? accQ[LOW_W-1:0]     : '0;
  assign sumOut[ACC_W-1:LOW_W] = strobes.showHigh ? accQ[ACC_W-1:LOW_W] : '0;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> accQ == '0); // R1
  AST_LOAD_SEL: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> accQ == $past(selVal)); // R3
  AST_SHIFT_ADD: assert property (@(posedge clk) disable iff (rst)
    (strobes.add && !$past(rst)) |=> accQ == $past(selVal) +
      {{SHIFT{$past(accQ[ACC_W-1])}}, $past(accQ[ACC_W-1:SHIFT])}); // R4
  AST_LOW_GATE: assert property (@(posedge clk) disable iff (rst)
    !strobes.showLow |-> sumOut[LOW_W-1:0] == '0); // R6
  AST_HIGH_GATE: assert property (@(posedge clk) disable iff (rst)
    !strobes.showHigh |-> sumOut[ACC_W-1:LOW_W] == '0); // R7
endmodule

// File: rtl/shaddOutStage.sv
module shaddOutStage
  import shadd_pkg::*;
#(
  parameter int CELLS = 8,
  parameter int ACC_W = 26,
  parameter int SHIFT = 8,
  parameter int LOW_W = 16,
  localparam int SEL_W = $clog2(CELLS)
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CELLS*ACC_W-1:0] cellAccFlat,
  input  logic [SEL_W-1:0]       cellSel,
  input  logic                   shiftAdd,
  input  logic                   enLow,
  input  logic                   enHigh,
  output logic [ACC_W-1:0]       sumOut
);
  shaddStrobeT strobes;

  shaddCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .shiftAdd (shiftAdd),
    .enLow    (enLow),
    .enHigh   (enHigh),
    .strobes  (strobes)
  );

  shaddDatapath #(
    .CELLS (CELLS),
    .ACC_W (ACC_W),
    .SHIFT (SHIFT),
    .LOW_W (LOW_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .cellAccFlat (cellAccFlat),
    .cellSel     (cellSel),
    .sumOut      (sumOut)
  );
endmodule

// File: tb/shaddOutStage_bench.sv
module shaddOutStage_bench;
  logic         clk = 0;
  logic         rst = 1;
  logic [207:0] cellAccFlat;
  logic [2:0]   cellSel = 0;
  logic         shiftAdd = 0, enLow = 1, enHigh = 1;
  logic [25:0]  sumOut;
  logic [25:0]  cellV [8];
  logic [25:0]  model = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb
    for (int k = 0; k < 8; k++) cellAccFlat[k*26 +: 26] = cellV[k];

  shaddOutStage u_shaddOutStage (
    .clk(clk), .rst(rst), .cellAccFlat(cellAccFlat), .cellSel(cellSel),
    .shiftAdd(shiftAdd), .enLow(enLow), .enHigh(enHigh), .sumOut(sumOut));

  function automatic logic [25:0] nextAcc(logic [25:0] acc, logic [25:0] c, bit sa);
    logic [25:0] sh;
    sh = {{8{acc[25]}}, acc[25:8]};
    return sa ? c + sh : c;
  endfunction

  function automatic logic [25:0] masked(logic [25:0] v, bit lo, bit hi);
    return {hi ? v[25:16] : 10'h0, lo ? v[15:0] : 16'h0};
  endfunction

  task automatic chk(input string tag, input logic [25:0] got, input logic [25:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int sel, input bit sa, input bit lo, input bit hi);
    @(negedge clk);
    cellSel = 3'(sel); shiftAdd = sa; enLow = lo; enHigh = hi;
    @(posedge clk);
    model = rst ? 26'h0 : nextAcc(model, cellV[sel], sa);
    #1;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) cellV[k] = 26'h0;
    void'($urandom(32'h5eed1234));
    // R1: reset clears
    cellV[0] = 26'h1234567;
    cyc(0, 0, 1, 1);
    cyc(0, 0, 1, 1);
    chk("R1 reset state", sumOut, 26'h0);
    @(negedge clk); rst = 0;
    // R2: each address
    for (int k = 0; k < 8; k++) cellV[k] = 26'(26'h0101010 * (k + 1) + 26'h3);
    for (int k = 0; k < 8; k++) begin
      cyc(k, 0, 1, 1);
      chk($sformatf("R2 select %0d", k), sumOut, cellV[k]);
    end
    // R3: load ignores old value
    cellV[1] = 26'h0000055;
    cyc(1, 0, 1, 1);
    chk("R3 load", sumOut, 26'h0000055);
    // R4: arithmetic shift of negative sum
    cellV[3] = 26'h2000000; cellV[0] = 26'h0;
    cyc(3, 0, 1, 1);
    cyc(0, 1, 1, 1);
    chk("R4 sign fill", sumOut, 26'h3FE0000);
    // R4: positive shift-add
    cellV[2] = 26'h0012300; cellV[4] = 26'h0000010;
    cyc(2, 0, 1, 1);
    cyc(4, 1, 1, 1);
    chk("R4 positive", sumOut, 26'h0000133);
    // R5: wrap through zero
    cellV[5] = 26'h0000100; cellV[6] = 26'h3FFFFFF;
    cyc(5, 0, 1, 1);
    cyc(6, 1, 1, 1);
    chk("R5 wrap", sumOut, 26'h0);
    // R6/R7: gating
    cellV[7] = 26'h3ABCDEF;
    cyc(7, 0, 1, 0);
    chk("R6 low only", sumOut, 26'h000CDEF);
    cyc(7, 0, 0, 1);
    chk("R7 high only", sumOut, 26'h3AB0000);
    cyc(7, 0, 0, 0);
    chk("R6 R7 both off", sumOut, 26'h0);
    // R8: no change before the edge
    cellV[1] = 26'h0AAAAAA;
    @(negedge clk);
    cellSel = 3'd1; shiftAdd = 0; enLow = 1; enHigh = 1;
    #1 chk("R8 before edge", sumOut, 26'h3ABCDEF);
    @(posedge clk); model = cellV[1]; #1;
    chk("R8 after edge", sumOut, 26'h0AAAAAA);
    // R9: 16 x 8 products in two passes
    for (int t = 0; t < 8; t++) begin
      logic signed [15:0] x;
      logic signed [7:0]  c;
      int p0, p1, comp, expP;
      logic [7:0] low8;
      x = (t == 0) ? -16'sd32768 : (t == 1) ? 16'sd32767 : 16'($urandom);
      c = (t == 0) ? -8'sd128 : (t == 1) ? -8'sd128 : 8'($urandom);
      p0 = int'({1'b0, x[7:0]}) * int'(c);
      p1 = int'($signed(x[15:8])) * int'(c);
      cellV[2] = 26'(p0); cellV[5] = 26'(p1);
      cyc(2, 0, 1, 1);
      low8 = sumOut[7:0];
      cyc(5, 1, 1, 1);
      comp = (int'($signed(sumOut)) * 256) + int'(low8);
      expP = int'(x) * int'(c);
      chk($sformatf("R9 product %0d", t), 26'(comp), 26'(expP));
    end
    // random mix
    for (int i = 0; i < 300; i++) begin
      int sel; bit sa, lo, hi;
      for (int k = 0; k < 8; k++) cellV[k] = 26'($urandom);
      sel = $urandom_range(0, 7); sa = 1'($urandom); lo = 1'($urandom); hi = 1'($urandom);
      cyc(sel, sa, lo, hi);
      chk(sa ? "R4 R5 random" : "R2 R3 random", sumOut, masked(model, lo, hi));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule